// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration front end that sits on a byte-wide host I/O bus and answers at two adjacent addresses. The lower address is the index port and the upper one is the data port. A host reaches a register by writing the register number to the index port and then reading or writing the data port.

The port is locked after reset. It opens only after an unlock key byte has been written to the index port twice in a row, and it closes again when a lock key byte is written there. While the port is open, the block serves a small set of global registers itself: a logical device number, a 16-bit device identifier, a revision byte and a 16-bit manufacturer identifier.

High indexes are not handled here. The block passes them to a logical-device register bus as a single-cycle strobe, and that bus carries the currently selected device number. A strap input picks one of two base addresses. Each host access takes one cycle. Read data is combinational in the cycle in which the read strobe is high. Control pins are plain strobes and there is no back-pressure.

Top module: `keyed_cfg_port`

## Requirements
- R1: The index port is at the base address and the data port is at base+1. The base address is 0x2E when `strap_alt` is 0 and 0x4E when it is 1. An access to any other address changes nothing, raises no strobe and reads 0xFF.
- R2: The port opens after two consecutive index-port writes of 0x87. The second key write is not stored as an index.
- R3: While the port is locked, an index-port write of any byte other than 0x87 that arrives after a first 0x87 cancels the partial key. A new pair of 0x87 writes is then needed.
- R4: While the port is open, an index-port write of 0xAA locks it and leaves the stored index unchanged.
- R5: While the port is locked, data-port writes are ignored, and reads of either port return 0xFF.
- R6: While the port is open, every other index-port write, 0x87 included, becomes the current index. An index-port read returns the current index.
- R7: Index 0x07 holds the logical device number. It can be read and written through the data port.
- R8: Data-port reads return fixed values at these indexes: 0x20 gives the device ID high byte, 0x21 the device ID low byte, 0x22 the revision, 0x23 gives 0x19 and 0x24 gives 0x34. Writes to these indexes are ignored.
- R9: When the port is open and the index is 0x30 or above, a data-port access raises `ld_strobe` in the same cycle. In that cycle `ld_write` is high for a write, `ld_offset` equals the index, `ld_dev` equals the logical device number and `ld_wdata` equals the write data. A read returns `ld_rdata`.
- R10: The remaining indexes below 0x30 read 0x00. Writes to them are ignored and raise no strobe.
- R11: After reset the port is locked, the index is 0x00 and the logical device number is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base address select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, 0xFF when the block is not addressed |
| ld_strobe | output | 1 | Logical-device register access |
| ld_write | output | 1 | High for a write on the logical-device bus |
| ld_dev | output | 8 | Selected logical device number |
| ld_offset | output | 8 | Register offset within the logical device |
| ld_wdata | output | 8 | Write data to the logical device |
| ld_rdata | input | 8 | Read data from the logical device |

## Verification
The bench breaks the key pair with a stray byte. It expects the port to stay locked, which catches a design that counts key bytes without requiring them to be consecutive. It then writes 0x87 again while the port is open and expects it to be stored as an index, which catches a design that keeps matching keys once open. It also checks that the lock key does not overwrite the index, that the read-only identifiers survive writes, and that index 0x2F stays local while 0x30 is forwarded. A wrong compare boundary would show up there as a missing or stray strobe. Finally, it swaps the strap and expects the old address to go silent, which catches a decoder that does not follow the strap.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_DID_HI = 8'h20;
  localparam logic [7:0] IDX_DID_LO = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_MFG_HI = 8'h23;
  localparam logic [7:0] IDX_MFG_LO = 8'h24;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import keyed_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  state_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
        KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  // R2: opening only follows an armed state plus a second key write
  a_r2_open_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(state_q == KS_ARMED && idx_wr && wdata == KEY_OPEN));

  // R3: a stray byte while armed drops back to locked
  a_r3_stray_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_ARMED && idx_wr && wdata != KEY_OPEN) |=> state_q == KS_LOCKED);

  // R4: close key locks the port
  a_r4_close_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && idx_wr && wdata == KEY_CLOSE) |=> !open_o);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import keyed_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID   = 16'hC4E1,
  parameter logic [7:0]  REV      = 8'h03,
  parameter logic [15:0] MFG_ID   = 16'h1934,
  parameter logic [7:0]  LD_FIRST = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index_o,
  output logic [7:0] ldn_o,
  output logic       fwd_o,
  output logic [7:0] local_rdata_o
);
  logic [7:0] index_q, ldn_q;
  logic       idx_load, ldn_load;

  assign idx_load = open && idx_wr && (wdata != KEY_CLOSE);
  assign fwd_o    = (index_q >= LD_FIRST);
  assign ldn_load = open && data_wr && (index_q == IDX_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_load) index_q <= wdata;
      if (ldn_load) ldn_q   <= wdata;
    end
  end

  always_comb begin
    unique case (index_q)
      IDX_LDN:    local_rdata_o = ldn_q;
      IDX_DID_HI: local_rdata_o = DEV_ID[15:8];
      IDX_DID_LO: local_rdata_o = DEV_ID[7:0];
      IDX_REV:    local_rdata_o = REV;
      IDX_MFG_HI: local_rdata_o = MFG_ID[15:8];
      IDX_MFG_LO: local_rdata_o = MFG_ID[7:0];
      default:    local_rdata_o = 8'h00;
    endcase
  end

  assign index_o = index_q;
  assign ldn_o   = ldn_q;

  // R6 / R4: index moves only on an open index write
  a_r6_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(open && idx_wr) |=> $stable(index_q));

  // R7 / R5: device number moves only on an open data write at 0x07
  a_r7_ldn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(open && data_wr && index_q == IDX_LDN) |=> $stable(ldn_q));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  parameter logic [15:0] DEV_ID   = 16'hC4E1,
  parameter logic [7:0]  REV      = 8'h03,
  parameter logic [15:0] MFG_ID   = 16'h1934,
  parameter logic [7:0]  LD_FIRST = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              ld_strobe,
  output logic              ld_write,
  output logic [7:0]        ld_dev,
  output logic [7:0]        ld_offset,
  output logic [7:0]        ld_wdata,
  input  logic [7:0]        ld_rdata
);
  localparam logic [ADDR_W-1:0] BASE_P = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ALT);

  logic [ADDR_W-1:0] base;
  logic hit_idx, hit_data, idx_wr, data_wr, open;
  logic [7:0] index, ldn, local_rdata;
  logic fwd;

  assign base     = strap_alt ? BASE_A : BASE_P;
  assign hit_idx  = (io_addr == base);
  assign hit_data = (io_addr == base + ADDR_W'(1));
  assign idx_wr   = hit_idx && io_wr;
  assign data_wr  = hit_data && io_wr && open;

  cfg_key_fsm u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (io_wdata),
    .open_o (open)
  );

  cfg_global_regs #(
    .DEV_ID   (DEV_ID),
    .REV      (REV),
    .MFG_ID   (MFG_ID),
    .LD_FIRST (LD_FIRST)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .open          (open),
    .idx_wr        (idx_wr),
    .data_wr       (data_wr),
    .wdata         (io_wdata),
    .index_o       (index),
    .ldn_o         (ldn),
    .fwd_o         (fwd),
    .local_rdata_o (local_rdata)
  );

  assign ld_strobe = open && hit_data && (io_wr || io_rd) && fwd;
  assign ld_write  = ld_strobe && io_wr;
  assign ld_dev    = ldn;
  assign ld_offset = index;
  assign ld_wdata  = io_wdata;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && open) begin
      if (hit_idx)       io_rdata = index;
      else if (hit_data) io_rdata = fwd ? ld_rdata : local_rdata;
    end
  end

  // R5: locked data-port reads float high
  a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_data && !open) |-> io_rdata == 8'hFF);

  // R9: forwarding only happens while open
  a_r9_strobe_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |-> open);

  // R1: forwarding only from the data port address
  a_r1_strobe_at_data_port: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |-> io_addr == (strap_alt ? BASE_A : BASE_P) + ADDR_W'(1));
endmodule

// File: tb/keyed_cfg_port_tb.sv
`timescale 1ns/1ps
module keyed_cfg_port_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, strap_alt, io_wr, io_rd;
  logic [15:0] io_addr;
  logic [7:0] io_wdata, io_rdata, ld_dev, ld_offset, ld_wdata, ld_rdata;
  logic ld_strobe, ld_write;

  // Responder: read data derived from offset and device
  assign ld_rdata = ld_offset ^ ld_dev ^ 8'h5A;

  keyed_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ld_strobe(ld_strobe), .ld_write(ld_write), .ld_dev(ld_dev),
    .ld_offset(ld_offset), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Behavioural reference state
  int m_st;            // 0 locked, 1 one key seen, 2 open
  int m_idx, m_ldn;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int id_byte(int idx);
    case (idx)
      'h07: return m_ldn;
      'h20: return 'hC4;
      'h21: return 'hE1;
      'h22: return 'h03;
      'h23: return 'h19;
      'h24: return 'h34;
      default: return 0;
    endcase
  endfunction

  task automatic step(string req, bit wr, bit rd, int addr, int d);
    int base, exp_rd, exp_stb;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = addr[15:0]; io_wdata = d[7:0];
    #1;
    base = strap_alt ? 'h4E : 'h2E;
    exp_stb = (m_st == 2 && addr == base + 1 && (wr || rd) && m_idx >= 'h30) ? 1 : 0;
    exp_rd = 'hFF;
    if (rd && m_st == 2) begin
      if (addr == base) exp_rd = m_idx;
      else if (addr == base + 1)
        exp_rd = (m_idx >= 'h30) ? ((m_idx ^ m_ldn ^ 'h5A) & 'hFF) : id_byte(m_idx);
    end
    chk(req, "io_rdata", int'(io_rdata), exp_rd);
    chk(req, "ld_strobe", int'(ld_strobe), exp_stb);
    if (exp_stb == 1) begin
      chk(req, "ld_write", int'(ld_write), int'(wr));
      chk(req, "ld_offset", int'(ld_offset), m_idx);
      chk(req, "ld_dev", int'(ld_dev), m_ldn);
      if (wr) chk(req, "ld_wdata", int'(ld_wdata), d);
    end
    @(posedge clk);
    if (wr && addr == base) begin
      if (m_st == 2) begin
        if (d == 'hAA) m_st = 0; else m_idx = d;
      end else if (m_st == 1) m_st = (d == 'h87) ? 2 : 0;
      else m_st = (d == 'h87) ? 1 : 0;
    end else if (wr && addr == base + 1 && m_st == 2 && m_idx == 'h07) begin
      m_ldn = d;
    end
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst_n = 0; strap_alt = strap; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "rdata in reset", int'(io_rdata), 'hFF);
    chk("R11", "strobe in reset", int'(ld_strobe), 0);
    rst_n = 1;
    m_st = 0; m_idx = 0; m_ldn = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(0);
    step("R5", 0, 1, 'h2F, 0);
    step("R5", 0, 1, 'h2E, 0);
    step("R5", 1, 0, 'h2F, 'h33);
    // R1: key at the wrong address does nothing
    step("R1", 1, 0, 'h4E, 'h87);
    step("R1", 1, 0, 'h4E, 'h87);
    step("R1", 0, 1, 'h2F, 0);
    // R3: broken pair
    step("R3", 1, 0, 'h2E, 'h87);
    step("R3", 1, 0, 'h2E, 'h55);
    step("R3", 1, 0, 'h2E, 'h87);
    step("R3", 0, 1, 'h2E, 0);
    // R2: proper pair after the single 0x87 above
    step("R2", 1, 0, 'h2E, 'h87);
    step("R11", 0, 1, 'h2E, 0);
    // R6: key byte stored as index when open
    step("R6", 1, 0, 'h2E, 'h87);
    step("R6", 0, 1, 'h2E, 0);
    step("R10", 0, 1, 'h2F, 0);
    // R7
    step("R7", 1, 0, 'h2E, 'h07);
    step("R11", 0, 1, 'h2F, 0);
    step("R7", 1, 0, 'h2F, 'h03);
    step("R7", 0, 1, 'h2F, 0);
    // R8
    for (int i = 'h20; i <= 'h24; i++) begin
      step("R8", 1, 0, 'h2E, i);
      step("R8", 0, 1, 'h2F, 0);
      step("R8", 1, 0, 'h2F, 'hFF);
      step("R8", 0, 1, 'h2F, 0);
    end
    // R10 boundaries
    step("R10", 1, 0, 'h2E, 'h10);
    step("R10", 1, 0, 'h2F, 'h77);
    step("R10", 0, 1, 'h2F, 0);
    step("R10", 1, 0, 'h2E, 'h2F);
    step("R10", 1, 0, 'h2F, 'h77);
    step("R10", 0, 1, 'h2F, 0);
    // R9 forwarding
    step("R9", 1, 0, 'h2E, 'h30);
    step("R9", 1, 0, 'h2F, 'hC3);
    step("R9", 0, 1, 'h2F, 0);
    step("R9", 1, 0, 'h2E, 'hFF);
    step("R9", 0, 1, 'h2F, 0);
    step("R9", 1, 0, 'h2E, 'h07);
    step("R9", 1, 0, 'h2F, 'h05);
    step("R9", 1, 0, 'h2E, 'h41);
    step("R9", 1, 0, 'h2F, 'h19);
    step("R9", 0, 1, 'h2F, 0);
    step("R1", 0, 1, 'h2D, 0);
    step("R1", 1, 0, 'h30, 'h12);
    // R4: close key, index kept
    step("R4", 1, 0, 'h2E, 'hAA);
    step("R4", 0, 1, 'h2F, 0);
    step("R5", 1, 0, 'h2F, 'h00);
    step("R4", 1, 0, 'h2E, 'h87);
    step("R4", 1, 0, 'h2E, 'h87);
    step("R4", 0, 1, 'h2E, 0);
    step("R4", 0, 1, 'h2F, 0);
    // R1: alternate strap
    do_reset(1);
    step("R1", 1, 0, 'h2E, 'h87);
    step("R1", 1, 0, 'h2E, 'h87);
    step("R1", 0, 1, 'h4E, 0);
    step("R1", 1, 0, 'h4E, 'h87);
    step("R1", 1, 0, 'h4E, 'h87);
    step("R1", 1, 0, 'h4E, 'h20);
    step("R1", 0, 1, 'h4F, 0);
    step("R1", 0, 1, 'h2F, 0);
    step("R1", 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule